// File: doc/BRIEF.md
# Load-Reserved Reservation Stack Tracker

This block keeps the load-reserved / store-conditional reservations of several hardware threads (harts). Each hart owns a small last-in-first-out list of reserved addresses. A load-reserved pushes the request address, rounded down to its 16-byte granule, onto the requesting hart's list. A store-conditional succeeds only when the newest entry of its hart equals its own granule address. A coherence snoop against a hart removes that hart's newest entry when the two fall in the same cache block. Older entries are never looked at by a snoop or by a store-conditional.

The block also counts consecutive store-conditional failures per hart and raises a one-cycle warning, tagged with the hart number, each time that count reaches a multiple of a parameterised period (10000 by default). The cache and the memory datapath sit outside the block. It has three request ports: load-reserved, store-conditional (with a registered result one cycle later) and snoop.

Each hart's list is a small state machine with three named states. LS_EMPTY holds no entry. LS_PART holds at least one entry but is not full. LS_FULL holds DEPTH entries. The transitions are: push (LS_EMPTY to LS_PART, or LS_PART to LS_FULL when the last slot fills); pop by a snoop hit or a store-conditional success (LS_FULL to LS_PART, or LS_PART to LS_EMPTY when the last entry leaves); and push-on-full, which stays in LS_FULL and drops the oldest entry. When pops and a push fall in the same cycle, the next state follows from the resulting fill level.

Top module: `resv_stack_tracker`

## Requirements
- R1: Requests carry a hart number. A load-reserved, store-conditional or snoop changes only the list of the hart it names. The other harts' lists and failure counts are unchanged.
- R2: A load-reserved stores its address with bits [3:0] cleared as the new newest entry of its hart.
- R3: A snoop on a hart with an empty list has no effect. Otherwise, if the newest entry and the snoop address agree in all bits above the low BLK_OFF_W bits, that newest entry is removed.
- R4: A snoop whose block matches only an older entry (not the newest one) removes nothing.
- R5: A store-conditional fails when its hart's list is empty, or when the newest entry differs from its address with bits [3:0] cleared. On failure the result bit is 0 and the list is unchanged.
- R6: On success the result bit is 1, the newest entry is removed, and that hart's consecutive-failure count returns to zero.
- R7: Each time a hart's consecutive-failure count reaches a multiple of WARN_PERIOD, warn_pulse is high for exactly one cycle, together with the result of that failing store-conditional, and warn_hart gives that hart's number.
- R8: A list holds at most DEPTH entries. A load-reserved on a full list discards the oldest entry and keeps the new one as the newest.
- R9: Within one cycle on the same hart, the snoop acts first, then the store-conditional, then the load-reserved push.
- R10: After reset every list is empty and every failure count is zero. sc_resp_valid and warn_pulse are low.
- R11: sc_resp_valid is high in exactly the cycle after each cycle with sc_valid high, and sc_resp_ok is only ever high together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | Load-reserved request |
| lr_hart | input | HID_W | Hart of the load-reserved |
| lr_addr | input | ADDR_W | Physical address of the load-reserved |
| sc_valid | input | 1 | Store-conditional request |
| sc_hart | input | HID_W | Hart of the store-conditional |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| snp_valid | input | 1 | Coherence snoop |
| snp_hart | input | HID_W | Hart whose list the snoop is checked against |
| snp_addr | input | ADDR_W | Snooped address |
| sc_resp_valid | output | 1 | Store-conditional result valid (one cycle after request) |
| sc_resp_ok | output | 1 | 1 = success, 0 = failure |
| warn_pulse | output | 1 | Failure-count warning, one cycle |
| warn_hart | output | HID_W | Hart that raised the warning |

## Verification
The hardest situation to reach is a cycle where snoop, store-conditional and load-reserved all hit the same hart. In that cycle the snoop must remove the newest entry and thereby expose an older one to the store-conditional. Random stimulus almost never builds that history, so directed steps first stack two reservations and then fire all three requests together. The same holds for the discard on a full list and for runs of consecutive failures long enough to cross the warning period. Directed sequences set these up, with the period reduced to 5 in the bench. A behavioural queue model then follows a long random phase over a small address set, so that matches, block-only matches and granule misses all occur often.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        LS_EMPTY = 2'd0,
        LS_PART  = 2'd1,
        LS_FULL  = 2'd2
    } lifo_state_e;

    localparam int GRAN_OFF_W = 4;
endpackage

// File: rtl/resv_lifo.sv
module resv_lifo
    import resv_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DEPTH     = 4,
    parameter int BLK_OFF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_req,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              lr_req,
    input  logic [ADDR_W-1:0] lr_addr,
    output logic              sc_ok
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ~((ADDR_W'(1) << BLK_OFF_W) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_OFF_W) - ADDR_W'(1));

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [LVL_W-1:0]  level, level1, level2, level_n;
    lifo_state_e       state, state_n;
    logic [ADDR_W-1:0] top0, top1;
    logic              snp_hit, is_empty;

    // state decode
    always_comb begin
        unique case (state)
            LS_EMPTY: is_empty = 1'b1;
            LS_PART:  is_empty = 1'b0;
            LS_FULL:  is_empty = 1'b0;
            default:  is_empty = 1'b1;
        endcase
    end

    // ordered update: snoop, then store-conditional, then push
    always_comb begin
        top0    = is_empty ? '0 : mem[IDX_W'(level - LVL_W'(1))];
        snp_hit = snp_req && !is_empty && (((top0 ^ snp_addr) & BLK_MASK) == '0);
        level1  = level - LVL_W'(snp_hit);
        top1    = (level1 == '0) ? '0 : mem[IDX_W'(level1 - LVL_W'(1))];
        sc_ok   = sc_req && (level1 != '0) && (top1 == (sc_addr & GRAN_MASK));
        level2  = level1 - LVL_W'(sc_ok);
        level_n = (lr_req && level2 != LVL_MAX) ? level2 + LVL_W'(1) : level2;
        if (level_n == '0)
            state_n = LS_EMPTY;
        else if (level_n == LVL_MAX)
            state_n = LS_FULL;
        else
            state_n = LS_PART;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LS_EMPTY;
            level <= '0;
        end else begin
            state <= state_n;
            level <= level_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (lr_req) begin
            if (level2 == LVL_MAX) begin
                for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
                mem[DEPTH-1] <= lr_addr & GRAN_MASK;
            end else begin
                mem[IDX_W'(level2)] <= lr_addr & GRAN_MASK;
            end
        end
    end

    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX);
    a_r10_state_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_EMPTY) == (level == '0));
    a_r3_empty_snoop_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && level == '0 && !lr_req) |=> (level == '0));
    a_r5_empty_sc_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !sc_ok);
endmodule

// File: rtl/fail_monitor.sv
module fail_monitor #(
    parameter int WARN_PERIOD = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail,
    input  logic pass,
    output logic warn
);
    localparam int PH_W = $clog2(WARN_PERIOD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_PERIOD - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            warn  <= 1'b0;
        end else begin
            warn <= 1'b0;
            if (pass) begin
                phase <= '0;
            end else if (fail) begin
                if (phase == PH_LAST) begin
                    phase <= '0;
                    warn  <= 1'b1;
                end else begin
                    phase <= phase + PH_W'(1);
                end
            end
        end
    end

    a_r7_warn_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> $past(fail));
    a_r6_pass_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> (phase == '0 && !warn));
endmodule

// File: rtl/resv_stack_tracker.sv
module resv_stack_tracker #(
    parameter int NUM_HARTS   = 2,
    parameter int ADDR_W      = 32,
    parameter int DEPTH       = 4,
    parameter int BLK_OFF_W   = 6,
    parameter int WARN_PERIOD = 10000,
    localparam int HID_W      = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_valid,
    input  logic [HID_W-1:0]  lr_hart,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_valid,
    input  logic [HID_W-1:0]  sc_hart,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snp_valid,
    input  logic [HID_W-1:0]  snp_hart,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sc_resp_valid,
    output logic              sc_resp_ok,
    output logic              warn_pulse,
    output logic [HID_W-1:0]  warn_hart
);
    logic [NUM_HARTS-1:0] ok_vec, sc_sel, warn_vec;
    logic [HID_W-1:0]     resp_hart;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic lr_sel, snp_sel;
        assign lr_sel    = lr_valid  && (lr_hart  == HID_W'(h));
        assign snp_sel   = snp_valid && (snp_hart == HID_W'(h));
        assign sc_sel[h] = sc_valid  && (sc_hart  == HID_W'(h));

        resv_lifo #(
            .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BLK_OFF_W(BLK_OFF_W)
        ) i_lifo (
            .clk(clk), .rst_n(rst_n),
            .snp_req(snp_sel), .snp_addr(snp_addr),
            .sc_req(sc_sel[h]), .sc_addr(sc_addr),
            .lr_req(lr_sel), .lr_addr(lr_addr),
            .sc_ok(ok_vec[h])
        );

        fail_monitor #(.WARN_PERIOD(WARN_PERIOD)) i_mon (
            .clk(clk), .rst_n(rst_n),
            .fail(sc_sel[h] && !ok_vec[h]),
            .pass(ok_vec[h]),
            .warn(warn_vec[h])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_resp_valid <= 1'b0;
            sc_resp_ok    <= 1'b0;
            resp_hart     <= '0;
        end else begin
            sc_resp_valid <= sc_valid;
            sc_resp_ok    <= |ok_vec;
            resp_hart     <= sc_hart;
        end
    end

    assign warn_pulse = |warn_vec;
    assign warn_hart  = resp_hart;

    a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |=> sc_resp_valid);
    a_r11_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |=> !sc_resp_valid);
    a_r11_ok_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sc_resp_ok |-> sc_resp_valid);
    a_r1_single_warn: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(warn_vec));
    a_r7_warn_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
        warn_pulse |-> (sc_resp_valid && !sc_resp_ok));
endmodule

// File: tb/test_resv_stack_tracker.sv
`timescale 1ns/1ps
module test_resv_stack_tracker;
    localparam int NH = 2, AW = 16, DP = 4, BO = 6, WP = 5;
    localparam realtime TCK = 8.0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lr_valid = 0, sc_valid = 0, snp_valid = 0;
    logic [0:0] lr_hart = 0, sc_hart = 0, snp_hart = 0;
    logic [AW-1:0] lr_addr = 0, sc_addr = 0, snp_addr = 0;
    logic sc_resp_valid, sc_resp_ok, warn_pulse;
    logic [0:0] warn_hart;

    always #(TCK/2) clk = ~clk;

    resv_stack_tracker #(.NUM_HARTS(NH), .ADDR_W(AW), .DEPTH(DP),
                         .BLK_OFF_W(BO), .WARN_PERIOD(WP)) i_resv_stack_tracker (
        .clk(clk), .rst_n(rst_n),
        .lr_valid(lr_valid), .lr_hart(lr_hart), .lr_addr(lr_addr),
        .sc_valid(sc_valid), .sc_hart(sc_hart), .sc_addr(sc_addr),
        .snp_valid(snp_valid), .snp_hart(snp_hart), .snp_addr(snp_addr),
        .sc_resp_valid(sc_resp_valid), .sc_resp_ok(sc_resp_ok),
        .warn_pulse(warn_pulse), .warn_hart(warn_hart));

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [AW-1:0] q [NH][$];
    int fc [NH];
    logic e_valid, e_ok, e_warn;
    logic [0:0] e_whart;

    task automatic model_reset();
        for (int h = 0; h < NH; h++) begin q[h].delete(); fc[h] = 0; end
    endtask

    // reference: snoop, then store-conditional, then push
    task automatic model_step();
        e_valid = sc_valid; e_ok = 0; e_warn = 0; e_whart = sc_hart;
        if (snp_valid && q[snp_hart].size() > 0)
            if ((q[snp_hart][$] >> BO) == (snp_addr >> BO)) void'(q[snp_hart].pop_back());
        if (sc_valid) begin
            if (q[sc_hart].size() > 0 && q[sc_hart][$] == (sc_addr & 16'hFFF0)) begin
                e_ok = 1; void'(q[sc_hart].pop_back()); fc[sc_hart] = 0;
            end else begin
                fc[sc_hart]++;
                if (fc[sc_hart] % WP == 0) e_warn = 1;
            end
        end
        if (lr_valid) begin
            if (q[lr_hart].size() == DP) void'(q[lr_hart].pop_front());
            q[lr_hart].push_back(lr_addr & 16'hFFF0);
        end
    endtask

    task automatic compare(string tag);
        bit bad = 0;
        n_cmp++;
        if (sc_resp_valid !== e_valid) bad = 1;
        if (e_valid && sc_resp_ok !== e_ok) bad = 1;
        if (!e_valid && sc_resp_ok !== 1'b0) bad = 1;
        if (warn_pulse !== e_warn) bad = 1;
        if (e_warn && warn_hart !== e_whart) bad = 1;
        if (bad) begin
            n_bad++;
            $display("FAIL %s t=%0t: actual valid=%b ok=%b warn=%b whart=%0d expected valid=%b ok=%b warn=%b whart=%0d",
                     tag, $time, sc_resp_valid, sc_resp_ok, warn_pulse, warn_hart,
                     e_valid, e_ok, e_warn, e_whart);
        end
    endtask

    task automatic step(input bit lv, input int lh, input int la,
                        input bit sv, input int sh, input int sa,
                        input bit nv, input int nh, input int na, input string tag);
        lr_valid = lv; lr_hart = 1'(lh); lr_addr = AW'(la);
        sc_valid = sv; sc_hart = 1'(sh); sc_addr = AW'(sa);
        snp_valid = nv; snp_hart = 1'(nh); snp_addr = AW'(na);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic lr(int h, int a, string t); step(1, h, a, 0, 0, 0, 0, 0, 0, t); endtask
    task automatic sc(int h, int a, string t); step(0, 0, 0, 1, h, a, 0, 0, 0, t); endtask
    task automatic snp(int h, int a, string t); step(0, 0, 0, 0, 0, 0, 1, h, a, t); endtask

    function automatic int pick_addr(int r);
        int base [4] = '{16'h1000, 16'h1010, 16'h1030, 16'h2000};
        return base[r % 4] + ((r >> 2) % 16);
    endfunction

    initial begin
        #(TCK * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        e_valid = 0; e_ok = 0; e_warn = 0; e_whart = 0;
        compare("R10 reset outputs");
        sc(0, 16'h0040, "R10 empty after reset");
        sc(1, 16'h0040, "R10 empty after reset");
        // R2 granule alignment
        lr(0, 16'h1234, "R2");
        sc(0, 16'h123C, "R2 aligned match");
        sc(0, 16'h1230, "R6 entry popped");
        // R1 hart isolation
        lr(0, 16'h0100, "R1");
        sc(1, 16'h0100, "R1 other hart empty");
        sc(0, 16'h0100, "R1 own hart intact");
        // R3 snoop
        snp(0, 16'h0200, "R3 empty snoop");
        lr(0, 16'h0200, "R3");
        sc(0, 16'h0200, "R3 no effect from earlier snoop");
        lr(0, 16'h0240, "R3");
        snp(1, 16'h0240, "R1 snoop other hart");
        sc(0, 16'h0240, "R1 snoop other hart ignored");
        lr(0, 16'h0240, "R3");
        snp(0, 16'h027F, "R3 same block");
        sc(0, 16'h0240, "R3 removed by snoop");
        // R4 deeper entries not examined
        lr(0, 16'h0300, "R4"); lr(0, 16'h0400, "R4");
        snp(0, 16'h0300, "R4 older block");
        sc(0, 16'h0400, "R4 top kept");
        sc(0, 16'h0300, "R4 older kept");
        // R5 granule mismatch
        lr(1, 16'h0500, "R5");
        sc(1, 16'h0510, "R5 mismatch fails");
        sc(1, 16'h0500, "R5 list unchanged after failure");
        // R8 overflow discards oldest
        for (int i = 1; i <= 5; i++) lr(0, i * 16'h10, "R8");
        for (int i = 5; i >= 2; i--) sc(0, i * 16'h10, "R8 kept entries");
        sc(0, 16'h0010, "R8 oldest discarded");
        // R9 ordering within a cycle
        lr(0, 16'h0500, "R9"); lr(0, 16'h0600, "R9");
        step(0, 0, 0, 1, 0, 16'h0500, 1, 0, 16'h0600, "R9 snoop before SC");
        lr(0, 16'h0800, "R9");
        step(1, 0, 16'h0900, 1, 0, 16'h0800, 0, 0, 0, "R9 SC before push");
        sc(0, 16'h0900, "R9 pushed entry present");
        step(1, 0, 16'h0A00, 1, 0, 16'h0A00, 0, 0, 0, "R9 push not visible to SC");
        sc(0, 16'h0A00, "R9");
        // R7 warning cadence
        lr(1, 16'h0C00, "R7"); sc(1, 16'h0C00, "R6 clears count");
        for (int i = 0; i < 12; i++) sc(1, 16'h0D00, "R7 failure run");
        sc(0, 16'h0D00, "R7 other hart count separate");
        lr(1, 16'h0E00, "R6"); sc(1, 16'h0E00, "R6 clears count");
        for (int i = 0; i < 4; i++) sc(1, 16'h0D00, "R6 restart below period");
        for (int i = 0; i < 6; i++) sc(0, 16'h0D00, "R7 hart 0 run");
        // R11 idle cycles produce no result
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r1 = $urandom, r2 = $urandom, r3 = $urandom;
            step(r1[0], r1[1], pick_addr(r1 >> 4),
                 r2[0] | r2[1], r2[2], pick_addr(r2 >> 4),
                 r3[0] & r3[1], r3[2], pick_addr(r3 >> 4),
                 "R5 R6 R7 R8 R9 R11 random");
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule